// File: doc/BRIEF.md
# HDLC Transmit FIFO Block Loader

This block feeds one outgoing frame from a frame buffer into the transmit FIFO of an HDLC controller. The frame is cut into blocks of at most `BLOCK_BYTES` bytes. Bytes are written one per cycle. After each block the loader issues a one-cycle command. Every block carries the transmit-FIFO bit, and only the block that ends the frame also carries the message-end bit. The loader then waits for the controller to report that its FIFO pool is ready again. When the controller reports a message repeat or a data underrun, the loader rewinds the frame to its first byte. The whole frame is then sent again from the next pool-ready strobe.

A new frame is taken only when four conditions hold: the line reports the fully active state, nothing is pending, the length is non-zero and the length does not exceed `MAX_FRAME`. Otherwise the offer is dropped without any trace at the FIFO side. The first block of an accepted frame starts at once. When a pool-ready strobe finds the frame fully loaded, the loader releases the frame and gives a one-cycle confirmation. HDLC framing, CRC and the serial line belong to the controller.

Top module: `hdlc_blk_loader`

## Requirements
- R1: A block writes at most `BLOCK_BYTES` (default 32) bytes, one per cycle with `fifoWr` high. Each byte is `bufData` read at `bufAddr`, and `bufAddr` is the byte offset within the frame. Offsets rise by one from 0 over the frame.
- R2: When more than `BLOCK_BYTES` bytes remain, exactly `BLOCK_BYTES` bytes are written. They are followed in the next cycle by a one-cycle `cmdValid` with `cmdXmitFifo`=1 and `cmdMsgEnd`=0.
- R3: When `BLOCK_BYTES` or fewer bytes remain (including exactly `BLOCK_BYTES`), all of them are written. They are followed in the next cycle by a one-cycle `cmdValid` with `cmdXmitFifo`=1 and `cmdMsgEnd`=1.
- R4: An accepted frame has its first byte on `fifoWr` in the cycle right after the clock edge that sampled `frameValid`.
- R5: A `poolReady` strobe while waiting, with bytes still left, starts the next block in the following cycle.
- R6: A `poolReady` strobe while waiting, with no bytes left, releases the frame. In the following cycle `confirm` is high for exactly one cycle and `busy` is low.
- R7: A `msgRepeat` or `underrun` strobe while waiting rewinds the frame to offset 0 and writes nothing. The next `poolReady` reloads the frame from its first byte.
- R8: When a rewind strobe and `poolReady` arrive in the same cycle, the rewind is applied first. A block from offset 0 is loaded and no confirmation is given, even if the frame had been fully loaded.
- R9: A frame offered while `lineActive` is low is discarded: `busy` stays low and nothing is written.
- R10: Lengths of 0 or above `MAX_FRAME` (default 300) are discarded. A length of exactly `MAX_FRAME` is accepted and sent in full.
- R11: `busy` is high from acceptance until release. A frame offered while busy is refused and does not alter the frame in progress.
- R12: A `poolReady` strobe while no frame is pending has no effect: no `confirm`, no write, `busy` stays low.
- R13: After reset `busy`, `fifoWr`, `cmdValid` and `confirm` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | One-cycle offer of a new frame |
| frameLen | input | LEN_W | Byte length of the offered frame |
| lineActive | input | 1 | Line is in the fully active state |
| bufAddr | output | LEN_W | Byte offset read from the frame buffer |
| bufData | input | DATA_W | Frame buffer byte at `bufAddr` (same cycle) |
| poolReady | input | 1 | Controller FIFO pool ready strobe |
| msgRepeat | input | 1 | Controller message-repeat strobe |
| underrun | input | 1 | Controller data-underrun strobe |
| fifoWr | output | 1 | FIFO write strobe |
| fifoData | output | DATA_W | Byte written to the FIFO |
| cmdValid | output | 1 | Command strobe |
| cmdXmitFifo | output | 1 | Transmit-FIFO command bit |
| cmdMsgEnd | output | 1 | Message-end command bit |
| confirm | output | 1 | Frame fully sent, one-cycle pulse |
| busy | output | 1 | A frame is pending |

## Verification
Rewind and pool-ready are the two functions that can fall in the same cycle, and the bench makes this happen on purpose. After the last block of a short frame has been loaded, it drives `underrun` and `poolReady` together in one cycle. A correct loader must favour the rewind. The scoreboard therefore expects the frame's first block again, and `confirm` is checked to stay low in the following cycle. A later lone `poolReady` must then produce the confirmation. A refused offer made while a block is being written is the other overlap that is exercised, and only the original frame's bytes may appear.

// File: rtl/hdlc_blk_pkg.sv
package hdlc_blk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CMD,
    ST_WAIT
  } blkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startFrame;   // latch a newly accepted frame, open its first block
    logic openBlock;    // size the next block from the remaining bytes
    logic stepByte;     // one byte moved to the FIFO
    logic rewindFrame;  // move back by the bytes already sent
    logic dropFrame;    // frame released, clear sent count
  } blkCtl_t;

endpackage

// File: rtl/hdlc_blk_dp.sv
module hdlc_blk_dp
  import hdlc_blk_pkg::*;
#(
  parameter int BLOCK_BYTES = 32,
  parameter int MAX_FRAME   = 300,
  parameter int DATA_W      = 8,
  localparam int LEN_W      = $clog2(MAX_FRAME + 1),
  localparam int BLK_W      = $clog2(BLOCK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  blkCtl_t           ctl,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [DATA_W-1:0] bufData,
  output logic [LEN_W-1:0]  bufAddr,
  output logic [DATA_W-1:0] fifoData,
  output logic              nextRemZero,
  output logic              blockLast,
  output logic              endFlag
);

  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] readPtr;
  logic [LEN_W-1:0] sentCnt;
  logic [BLK_W-1:0] blkLeft;
  logic [LEN_W-1:0] basePtr;
  logic [LEN_W-1:0] nextRem;

  function automatic logic [BLK_W-1:0] blkSize(input logic [LEN_W-1:0] rem);
    return (rem > LEN_W'(BLOCK_BYTES)) ? BLK_W'(BLOCK_BYTES) : BLK_W'(rem);
  endfunction

  // rewind is applied before the remaining count is judged
  always_comb begin
    basePtr     = ctl.rewindFrame ? (readPtr - sentCnt) : readPtr;
    nextRem     = lenReg - basePtr;
    nextRemZero = (nextRem == '0);
    blockLast   = (blkLeft == BLK_W'(1));
    bufAddr     = readPtr;
    fifoData    = bufData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg  <= '0;
      readPtr <= '0;
      sentCnt <= '0;
      blkLeft <= '0;
      endFlag <= 1'b0;
    end else if (ctl.startFrame) begin
      lenReg  <= frameLen;
      readPtr <= '0;
      sentCnt <= '0;
      blkLeft <= blkSize(frameLen);
      endFlag <= (frameLen <= LEN_W'(BLOCK_BYTES));
    end else begin
      if (ctl.rewindFrame) begin
        readPtr <= basePtr;
        sentCnt <= '0;
      end
      if (ctl.openBlock) begin
        blkLeft <= blkSize(nextRem);
        endFlag <= (nextRem <= LEN_W'(BLOCK_BYTES));
      end
      if (ctl.stepByte) begin
        readPtr <= readPtr + LEN_W'(1);
        sentCnt <= sentCnt + LEN_W'(1);
        blkLeft <= blkLeft - BLK_W'(1);
      end
      if (ctl.dropFrame) begin
        sentCnt <= '0;
      end
    end
  end

endmodule

// File: rtl/hdlc_blk_ctrl.sv
module hdlc_blk_ctrl
  import hdlc_blk_pkg::*;
#(
  parameter int MAX_FRAME = 300,
  localparam int LEN_W    = $clog2(MAX_FRAME + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameValid,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             lineActive,
  input  logic             poolReady,
  input  logic             msgRepeat,
  input  logic             underrun,
  input  logic             nextRemZero,
  input  logic             blockLast,
  output blkCtl_t          ctl,
  output logic             fifoWr,
  output logic             cmdValid,
  output logic             confirm,
  output logic             busy
);

  blkState_t st, stNext;
  logic      lenOk;
  logic      finish;

  assign lenOk = (frameLen != '0) && (frameLen <= LEN_W'(MAX_FRAME));

  always_comb begin
    ctl    = '0;
    stNext = st;
    finish = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (frameValid && lineActive && lenOk) begin
          ctl.startFrame = 1'b1;
          stNext         = ST_LOAD;
        end
      end
      ST_LOAD: begin
        ctl.stepByte = 1'b1;
        if (blockLast) stNext = ST_CMD;
      end
      ST_CMD: stNext = ST_WAIT;
      ST_WAIT: begin
        ctl.rewindFrame = msgRepeat | underrun;
        if (poolReady) begin
          if (nextRemZero) begin
            ctl.dropFrame = 1'b1;
            finish        = 1'b1;
            stNext        = ST_IDLE;
          end else begin
            ctl.openBlock = 1'b1;
            stNext        = ST_LOAD;
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      confirm <= 1'b0;
    end else begin
      st      <= stNext;
      confirm <= finish;
    end
  end

  assign fifoWr   = (st == ST_LOAD);
  assign cmdValid = (st == ST_CMD);
  assign busy     = (st != ST_IDLE);

endmodule

// File: rtl/hdlc_blk_loader.sv
module hdlc_blk_loader
  import hdlc_blk_pkg::*;
#(
  parameter int BLOCK_BYTES = 32,
  parameter int MAX_FRAME   = 300,
  parameter int DATA_W      = 8,
  localparam int LEN_W      = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              lineActive,
  output logic [LEN_W-1:0]  bufAddr,
  input  logic [DATA_W-1:0] bufData,
  input  logic              poolReady,
  input  logic              msgRepeat,
  input  logic              underrun,
  output logic              fifoWr,
  output logic [DATA_W-1:0] fifoData,
  output logic              cmdValid,
  output logic              cmdXmitFifo,
  output logic              cmdMsgEnd,
  output logic              confirm,
  output logic              busy
);

  blkCtl_t ctl;
  logic    nextRemZero;
  logic    blockLast;
  logic    endFlag;

  hdlc_blk_ctrl #(.MAX_FRAME(MAX_FRAME)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .frameValid(frameValid), .frameLen(frameLen), .lineActive(lineActive),
    .poolReady(poolReady), .msgRepeat(msgRepeat), .underrun(underrun),
    .nextRemZero(nextRemZero), .blockLast(blockLast),
    .ctl(ctl), .fifoWr(fifoWr), .cmdValid(cmdValid),
    .confirm(confirm), .busy(busy)
  );

  hdlc_blk_dp #(.BLOCK_BYTES(BLOCK_BYTES), .MAX_FRAME(MAX_FRAME), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .frameLen(frameLen),
    .bufData(bufData), .bufAddr(bufAddr), .fifoData(fifoData),
    .nextRemZero(nextRemZero), .blockLast(blockLast), .endFlag(endFlag)
  );

  assign cmdXmitFifo = cmdValid;
  assign cmdMsgEnd   = cmdValid & endFlag;

endmodule

// File: rtl/hdlc_blk_checker.sv
module hdlc_blk_checker #(
  parameter int BLOCK_BYTES = 32,
  parameter int MAX_FRAME   = 300,
  localparam int LEN_W      = $clog2(MAX_FRAME + 1),
  localparam int RUN_W      = $clog2(BLOCK_BYTES + 1) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameValid,
  input logic [LEN_W-1:0] frameLen,
  input logic             lineActive,
  input logic             poolReady,
  input logic             busy,
  input logic             fifoWr,
  input logic             cmdValid,
  input logic             cmdXmitFifo,
  input logic             confirm
);

  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN)       runCnt <= '0;
    else if (fifoWr) runCnt <= runCnt + RUN_W'(1);
    else             runCnt <= '0;
  end

  p_block_len_r1: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |-> (runCnt < RUN_W'(BLOCK_BYTES)));

  p_cmd_after_bytes_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(fifoWr));

  p_cmd_xfifo_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdXmitFifo);

  p_accept_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && frameValid && lineActive && frameLen != '0 &&
     frameLen <= LEN_W'(MAX_FRAME)) |=> fifoWr);

  p_confirm_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    confirm |=> !confirm);

  p_confirm_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    confirm |-> !busy);

  p_line_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !lineActive) |=> !busy);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!fifoWr && !cmdValid));

  p_idle_pool_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && poolReady && !frameValid) |=> (!confirm && !busy));

endmodule

bind hdlc_blk_loader hdlc_blk_checker #(.BLOCK_BYTES(BLOCK_BYTES), .MAX_FRAME(MAX_FRAME)) u_chk (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameLen(frameLen),
  .lineActive(lineActive), .poolReady(poolReady), .busy(busy),
  .fifoWr(fifoWr), .cmdValid(cmdValid), .cmdXmitFifo(cmdXmitFifo),
  .confirm(confirm)
);

// File: tb/hdlc_blk_loader_bench.sv
module hdlc_blk_loader_bench;

  localparam int BLK = 32;
  localparam int MAXF = 300;
  localparam int LW = $clog2(MAXF + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameValid = 1'b0;
  logic [LW-1:0] frameLen = '0;
  logic lineActive = 1'b1;
  logic [LW-1:0] bufAddr;
  logic [7:0] bufData;
  logic poolReady = 1'b0, msgRepeat = 1'b0, underrun = 1'b0;
  logic fifoWr, cmdValid, cmdXmitFifo, cmdMsgEnd, confirm, busy;
  logic [7:0] fifoData;

  logic [7:0] mem [0:511];
  logic [10:0] expQ [$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign bufData = mem[bufAddr];

  hdlc_blk_loader #(.BLOCK_BYTES(BLK), .MAX_FRAME(MAXF), .DATA_W(8)) u_hdlc_blk_loader (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameLen(frameLen),
    .lineActive(lineActive), .bufAddr(bufAddr), .bufData(bufData),
    .poolReady(poolReady), .msgRepeat(msgRepeat), .underrun(underrun),
    .fifoWr(fifoWr), .fifoData(fifoData), .cmdValid(cmdValid),
    .cmdXmitFifo(cmdXmitFifo), .cmdMsgEnd(cmdMsgEnd),
    .confirm(confirm), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: item = {isCmd, msgEnd, xmitFifo, data}
  always @(negedge clk) begin
    if (rstN && (fifoWr || cmdValid)) begin
      logic [10:0] act;
      act = fifoWr ? {3'b000, fifoData} : {1'b1, cmdMsgEnd, cmdXmitFifo, 8'h00};
      if (expQ.size() == 0) begin
        chk(1'b0, "R1/R2/R3/R9/R11 unexpected output", int'(act), 0);
      end else begin
        logic [10:0] exp;
        exp = expQ.pop_front();
        chk(act == exp, "R1/R2/R3 block stream", int'(act), int'(exp));
      end
    end
  end

  task automatic fill(input int len, input int seed);
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 7 + seed) & 8'hff);
  endtask

  // R1 R2 R3: expected bytes of one block and its command
  task automatic pushBlock(input int start, input int len);
    int n;
    n = (len - start > BLK) ? BLK : len - start;
    for (int k = 0; k < n; k++) expQ.push_back({3'b000, mem[start + k]});
    expQ.push_back({1'b1, (start + n == len), 1'b1, 8'h00});
  endtask

  task automatic offer(input int len, input bit line);
    @(negedge clk);
    frameValid = 1'b1; frameLen = LW'(len); lineActive = line;
    @(negedge clk);
    frameValid = 1'b0; lineActive = 1'b1;
  endtask

  task automatic pool(input bit pr, input bit rep, input bit und);
    @(negedge clk);
    poolReady = pr; msgRepeat = rep; underrun = und;
    @(negedge clk);
    poolReady = 1'b0; msgRepeat = 1'b0; underrun = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runFrame(input int len, input int seed, input string req);
    int pos;
    fill(len, seed);
    pushBlock(0, len);
    offer(len, 1'b1);
    chk(busy == 1'b1, "R4/R11 busy after accept", busy, 1);
    pos = (len > BLK) ? BLK : len;
    forever begin
      drain();
      if (pos < len) begin
        pushBlock(pos, len);
        pos += (len - pos > BLK) ? BLK : len - pos;
        pool(1'b1, 1'b0, 1'b0);   // R5
      end else begin
        pool(1'b1, 1'b0, 1'b0);
        chk(confirm == 1'b1, {req, " R6 confirm"}, confirm, 1);
        chk(busy == 1'b0, {req, " R6 released"}, busy, 0);
        @(negedge clk);
        chk(confirm == 1'b0, "R6 confirm one cycle", confirm, 0);
        break;
      end
    end
  endtask

  task automatic quiet(input string req);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, req, busy, 0);
    chk(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13
    chk(!busy && !fifoWr && !cmdValid && !confirm, "R13 reset state",
        int'({busy, fifoWr, cmdValid, confirm}), 0);

    runFrame(10, 1, "R3 short");
    runFrame(BLK, 2, "R3 exact block");
    runFrame(BLK + 1, 3, "R2 one over");
    runFrame(100, 4, "R2 multi");
    runFrame(MAXF, 5, "R10 max length");

    // R9 line not active
    offer(8, 1'b0);
    quiet("R9 dropped while line inactive");
    // R10 bad lengths
    offer(0, 1'b1);
    quiet("R10 zero length dropped");
    offer(MAXF + 1, 1'b1);
    quiet("R10 overlong dropped");
    // R12 pool ready while idle
    pool(1'b1, 1'b0, 1'b0);
    chk(confirm == 1'b0, "R12 no confirm when idle", confirm, 0);
    quiet("R12 idle pool ignored");

    // R11 refusal while busy
    fill(40, 6);
    pushBlock(0, 40);
    offer(40, 1'b1);
    repeat (3) @(negedge clk);
    offer(5, 1'b1);
    chk(busy == 1'b1, "R11 busy during load", busy, 1);
    drain();
    pushBlock(BLK, 40);
    pool(1'b1, 1'b0, 1'b0);
    drain();
    pool(1'b1, 1'b0, 1'b0);
    chk(confirm == 1'b1, "R11 original frame confirmed", confirm, 1);

    // R7 rewind by message repeat, then by underrun
    fill(70, 7);
    pushBlock(0, 70);
    offer(70, 1'b1);
    drain();
    pool(1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk(busy == 1'b1 && expQ.size() == 0, "R7 rewind writes nothing", busy, 1);
    pushBlock(0, 70);
    pool(1'b1, 1'b0, 1'b0);
    drain();
    pushBlock(BLK, 70);
    pool(1'b1, 1'b0, 1'b0);
    drain();
    pool(1'b0, 1'b0, 1'b1);
    pushBlock(0, 70);
    pool(1'b1, 1'b0, 1'b0);
    drain();
    pushBlock(BLK, 70);
    pool(1'b1, 1'b0, 1'b0);
    drain();
    pushBlock(2 * BLK, 70);
    pool(1'b1, 1'b0, 1'b0);
    drain();
    pool(1'b1, 1'b0, 1'b0);
    chk(confirm == 1'b1, "R7 frame confirmed after resend", confirm, 1);

    // R8 rewind and pool ready in the same cycle after final block
    fill(20, 8);
    pushBlock(0, 20);
    offer(20, 1'b1);
    drain();
    pushBlock(0, 20);
    pool(1'b1, 1'b0, 1'b1);
    chk(confirm == 1'b0, "R8 no confirm on collision", confirm, 0);
    chk(busy == 1'b1, "R8 still busy on collision", busy, 1);
    drain();
    pool(1'b1, 1'b0, 1'b0);
    chk(confirm == 1'b1, "R8 confirm after resend", confirm, 1);

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R1 scoreboard empty", expQ.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule